// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter

This block is a down-counter with a 16-bit count by default, driven by a tick from a selectable prescaler on the bus clock. Software programs it through a small register bus with three word addresses: a control byte, a sticky underflow flag and a count/load word. The counter either runs once and parks at zero (single-shot) or reloads itself after reaching zero (periodic). Each arrival at zero raises a flag that can drive an interrupt line.

The count/load address has two uses. A write always updates the load register. In single-shot mode the write also starts the counter from the new value. A read returns the live count or the load register, chosen by a control bit. A force-load control restarts the counter from the load register at any time. Byte writes to the upper half of the count word are held in a staging byte until the low byte is written, so a 16-bit value is never committed half-updated. Clearing the run bit parks the counter at all ones and holds the prescaler.

Top module: `moddown_timer`

## Requirements
- R1: After reset the control register reads 0x00, the count address reads 0xFFFF, the flag reads 0 and `irq` is 0.
- R2: Addresses are 0 = control, 1 = flag (bit 0), 2 = count/load. A read returns data on `bus_rdata` one clock after `bus_rd`. Control bits 7..0 are: interrupt enable, periodic mode, read-load select, capture-latch (stored and read back only), force load, run, prescale select [1:0].
- R3: While running, the count decreases by exactly one per prescaler tick. Prescale select 0, 1, 2 and 3 give one tick every 1, 4, 8 and 16 clocks, counted from the last load.
- R4: In single-shot mode (bit 6 = 0), a committed write to address 2 loads both the load register and the counter. The count then falls to 0x0000 and holds there.
- R5: In periodic mode (bit 6 = 1), a write to address 2 updates only the load register. A tick at 0x0000 reloads the counter from the load register, so a load value L repeats every L+1 ticks.
- R6: Writing control with bit 3 = 1 while running copies the load register into the counter and restarts the prescaler. Bit 3 always reads back 0.
- R7: With bit 5 = 0, reads of address 2 return the live count. With bit 5 = 1, they return the load register.
- R8: While bit 2 (run) is 0, the counter reads 0xFFFF and writes to address 2 do not start it.
- R9: The flag (address 1, bit 0) sets when a tick moves the count from 1 to 0. Loading 0 does not set it. Writing 1 to bit 0 clears it; writing 0 leaves it set.
- R10: `irq` is high one clock after the flag and bit 7 are both 1, and low one clock after either is 0.
- R11: A write to address 2 with only `bus_be[1]` set changes neither register and only stages the high byte. A later write with `bus_be[0]` commits the staged high byte together with the new low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_be | input | CNT_W/8 | Byte enables for writes |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Registered underflow interrupt |

## Verification
The bench builds the block with its defaults: a 16-bit count, two byte lanes and a 4-bit prescaler counter. These defaults make all four divisors and the high-byte staging path reachable. Randomized load values are kept at 20 or below and wait windows at 60 clocks or below. Under those limits, periodic runs wrap several times within one window, and single-shot runs are seen both before and after they reach zero. This exposes the reload spacing, the flag and interrupt timing, and the rule that the counter parks at zero.

// File: rtl/moddown_pkg.sv
package moddown_pkg;

  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADR_CTRL  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_FLAG  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_COUNT = 2'd2;

  // bit order is the programming model
  typedef struct packed {
    logic       irq_en;
    logic       reload;
    logic       rd_load;
    logic       cap_latch;
    logic       force_ld;
    logic       run;
    logic [1:0] psel;
  } ctrl_t;

endpackage

// File: rtl/moddown_prescaler.sv
module moddown_prescaler #(
  parameter int PS_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PS_W-1:0] pcnt_q;
  logic [PS_W-1:0] limit;

  always_comb begin
    case (psel)
      2'd0:    limit = '0;
      2'd1:    limit = PS_W'(3);
      2'd2:    limit = PS_W'(7);
      default: limit = PS_W'(15);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pcnt_q <= '0;
    end else if (pcnt_q == limit) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign tick = run && !restart && (pcnt_q == limit);

endmodule

// File: rtl/moddown_regs.sv
module moddown_regs
  import moddown_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BE_W = CNT_W / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]      wdata,
  input  logic [BE_W-1:0]       be,
  input  logic                  flag_set,
  output ctrl_t                 ctrl_q,
  output logic [CNT_W-1:0]      load_q,
  output logic                  commit,
  output logic [CNT_W-1:0]      commit_val,
  output logic                  ctrl_wr,
  output logic                  run_wr_val,
  output logic                  force_pulse,
  output logic                  flag_q
);

  logic cnt_sel;
  logic flag_clr;

  assign cnt_sel     = wr_en && (addr == ADR_COUNT);
  assign commit      = cnt_sel && be[0];
  assign ctrl_wr     = wr_en && (addr == ADR_CTRL) && be[0];
  assign run_wr_val  = wdata[2];
  assign force_pulse = ctrl_wr && wdata[3];
  assign flag_clr    = wr_en && (addr == ADR_FLAG) && be[0] && wdata[0];

  assign commit_val[7:0] = wdata[7:0];

  for (genvar g = 1; g < BE_W; g++) begin : g_lane
    logic [7:0] stage_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
      end else if (cnt_sel && be[g] && !be[0]) begin
        stage_q <= wdata[g*8 +: 8];
      end
    end
    assign commit_val[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q          <= ctrl_t'(wdata[7:0]);
      ctrl_q.force_ld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
    end else if (commit) begin
      load_q <= commit_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (flag_set) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/moddown_counter.sv
module moddown_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_eff,
  input  logic             tick,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_set
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;

  assign at_zero  = (cnt_q == '0);
  assign flag_set = run_eff && !load_now && tick && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst || !run_eff) begin
      cnt_q <= '1;
    end else if (load_now) begin
      cnt_q <= load_val;
    end else if (tick) begin
      if (at_zero) begin
        cnt_q <= reload_mode ? reload_val : cnt_q;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

endmodule

// File: rtl/moddown_timer.sv
module moddown_timer
  import moddown_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4,
  localparam int BE_W = CNT_W / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  input  logic [BE_W-1:0]       bus_be,
  output logic [CNT_W-1:0]      bus_rdata,
  output logic                  irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic             commit;
  logic [CNT_W-1:0] commit_val;
  logic             ctrl_wr;
  logic             run_wr_val;
  logic             force_pulse;
  logic             flag_q;
  logic             flag_set;
  logic [CNT_W-1:0] cnt_q;
  logic             run_eff;
  logic             load_now;
  logic [CNT_W-1:0] load_val;
  logic             tick;

  moddown_regs #(.CNT_W(CNT_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .be          (bus_be),
    .flag_set    (flag_set),
    .ctrl_q      (ctrl_q),
    .load_q      (load_q),
    .commit      (commit),
    .commit_val  (commit_val),
    .ctrl_wr     (ctrl_wr),
    .run_wr_val  (run_wr_val),
    .force_pulse (force_pulse),
    .flag_q      (flag_q)
  );

  assign run_eff  = ctrl_wr ? run_wr_val : ctrl_q.run;
  assign load_now = (commit && !ctrl_q.reload) || force_pulse;
  assign load_val = commit ? commit_val : load_q;

  moddown_prescaler #(.PS_W(PS_W)) ps_i (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run && run_eff),
    .restart (load_now),
    .psel    (ctrl_q.psel),
    .tick    (tick)
  );

  moddown_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst         (rst),
    .run_eff     (run_eff),
    .tick        (tick),
    .load_now    (load_now),
    .load_val    (load_val),
    .reload_val  (load_q),
    .reload_mode (ctrl_q.reload),
    .cnt_q       (cnt_q),
    .flag_set    (flag_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADR_CTRL:  bus_rdata <= {{(CNT_W-8){1'b0}}, ctrl_q};
        ADR_FLAG:  bus_rdata <= {{(CNT_W-1){1'b0}}, flag_q};
        ADR_COUNT: bus_rdata <= ctrl_q.rd_load ? load_q : cnt_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= flag_q && ctrl_q.irq_en;
    end
  end

endmodule

// File: rtl/moddown_timer_chk.sv
module moddown_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q,
  input logic             reload_q,
  input logic             flag_q,
  input logic             irq_en_q,
  input logic             irq
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_parked_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !bus_wr) |=> (cnt_q == '1));

  assert_single_shot_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && !reload_q && cnt_q == '0 && !bus_wr) |=> (cnt_q == '0));

  assert_flag_on_transition_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (cnt_q == '0 && $past(cnt_q) == ONE));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_q && irq_en_q) |=> irq);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (!flag_q || !irq_en_q) |=> !irq);

  assert_step_of_one_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && !bus_wr && cnt_q != '0) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - ONE)));

endmodule

bind moddown_timer moddown_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .cnt_q    (cnt_q),
  .run_q    (ctrl_q.run),
  .reload_q (ctrl_q.reload),
  .flag_q   (flag_q),
  .irq_en_q (ctrl_q.irq_en),
  .irq      (irq)
);

// File: tb/moddown_timer_tb_top.sv
module moddown_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [1:0]        bus_addr = '0;
  logic [CNT_W-1:0]  bus_wdata = '0;
  logic [1:0]        bus_be = '0;
  logic [CNT_W-1:0]  bus_rdata;
  logic              irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  moddown_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  function automatic int divisor(input int ps);
    return (ps == 0) ? 1 : (1 << (ps + 1));
  endfunction

  function automatic int exp_count(input int l, input int t, input bit per);
    if (per) return l - (t % (l + 1));
    return (t >= l) ? 0 : l - t;
  endfunction

  function automatic int exp_flag(input int l, input int t);
    return (l > 0 && t >= l) ? 1 : 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 count", v, 16'hFFFF);
    rd(2'd1, v); chk("R1 flag", v, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 capture-latch bit is stored and read back
    wr(2'd0, 16'h0010, 2'b11);
    rd(2'd0, v); chk("R2 ctrl readback", v, 16'h0010);

    // R11 staged high byte, R7 load select, R8 parked while stopped
    wr(2'd0, 16'h0020, 2'b11);
    wr(2'd2, 16'hAB00, 2'b10);
    rd(2'd2, v); chk("R11 high byte staged only", v, 0);
    wr(2'd2, 16'h0034, 2'b01);
    rd(2'd2, v); chk("R11 commit merged", v, 16'hAB34);
    wr(2'd0, 16'h0000, 2'b11);
    rd(2'd2, v); chk("R8 stopped count", v, 16'hFFFF);
    chk("R7 live count", v, 16'hFFFF);

    // R6 force load in periodic mode
    wr(2'd0, 16'h004C, 2'b11);
    rd(2'd2, v); chk("R6 forced count", v, 16'hAB34);
    rd(2'd0, v); chk("R6 force reads zero", v, 16'h0044);

    // R9 flag set, write 0 keeps it, write 1 clears it
    wr(2'd0, 16'h0000, 2'b11);
    wr(2'd0, 16'h0004, 2'b11);
    wr(2'd2, 16'h0002, 2'b11);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R9 flag set", v, 1);
    rd(2'd2, v); chk("R4 held at zero", v, 0);
    wr(2'd1, 16'h0000, 2'b11);
    rd(2'd1, v); chk("R9 write 0 keeps", v, 1);
    wr(2'd1, 16'h0001, 2'b11);
    rd(2'd1, v); chk("R9 write 1 clears", v, 0);
    wr(2'd2, 16'h0000, 2'b11);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R9 load of zero no flag", v, 0);

    // R3 divide by 16
    wr(2'd2, 16'd100, 2'b11);
    wr(2'd0, 16'h0007, 2'b11);
    wr(2'd0, 16'h000F, 2'b11);
    repeat (35) @(negedge clk);
    rd(2'd2, v); chk("R3 divide by 16", v, 98);

    // randomized runs: R3 R4 R5 R9 R10
    for (int it = 0; it < 60; it++) begin
      int l, ps, w, t;
      bit per, ie;
      logic [7:0] cb;
      l   = $urandom_range(0, 20);
      ps  = $urandom_range(0, 3);
      w   = $urandom_range(0, 60);
      per = 1'($urandom_range(0, 1));
      ie  = 1'($urandom_range(0, 1));
      cb  = {ie, per, 1'b0, 1'b0, 1'b0, 1'b1, 2'(ps)};
      wr(2'd0, 16'h0000, 2'b11);
      wr(2'd1, 16'h0001, 2'b11);
      wr(2'd0, {8'h00, cb}, 2'b11);
      wr(2'd2, 16'(l), 2'b11);
      if (per) wr(2'd0, {8'h00, cb | 8'h08}, 2'b11);
      repeat (w) @(negedge clk);
      t = w / divisor(ps);
      rd(2'd2, v);
      chk(per ? "R5 periodic count" : "R4 single-shot count", v, exp_count(l, t, per));
      t = (w + 1) / divisor(ps);
      rd(2'd1, v);
      chk("R9 flag after run", v, exp_flag(l, t));
      chk("R10 irq", int'(irq), (ie && exp_flag(l, t) == 1) ? 1 : 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule